// File: doc/BRIEF.md
# Half to Single Precision Widening Converter

This block turns a 16-bit binary16 bit pattern into the binary32 value that holds the same number. Because every half value can be written exactly in the wider format, no rounding takes place. The conversion is a pure bit rearrangement:

- The sign moves to the top bit.
- Normal exponents are rebiased.
- Subnormal halves are renormalized into normal wide values.
- Zeros stay signed zeros.
- Infinities and NaNs keep their 10-bit payload untouched.

Renormalization uses a single-cycle leading-one search over the 10 mantissa bits. The subnormal exponent is derived from the position of that leading one.

A parameter selects binary64 output, using the same rules with the wider exponent bias. A second parameter chooses between a registered output with one cycle of latency and a purely combinational path. A valid strobe travels alongside the data.

Top module: `hw_widen`

## Requirements
- R1: Input bit 15 (sign) appears unchanged in the most significant output bit, for every input class.
- R2: An input whose bits 14:0 are all zero produces an output whose bits below the sign are all zero (signed zero).
- R3: An input with exponent field (bits 14:10) zero and a nonzero mantissa (bits 9:0) is renormalized. Let p be the bit index of the highest set mantissa bit. The output exponent is 103+p for binary32 output and 999+p for binary64 output. The output mantissa top 10 bits are the mantissa shifted left by 10-p, keeping the low 10 bits. All lower mantissa bits are zero.
- R4: An input exponent field of 31 gives an all-ones output exponent. The 10 input mantissa bits are copied into the top 10 output mantissa bits (bits 22:13 for binary32), with zeros below, so NaN payloads are kept.
- R5: An input exponent field from 1 to 30 gives an output exponent equal to that field plus 112 (plus 1008 for binary64). The mantissa is placed in the top 10 output mantissa bits, with zeros below.
- R6: With the registered output, `out_valid` equals `in_valid` of the previous clock, and `out_wide` loads a new result only in cycles where `in_valid` is high; otherwise it holds. Synchronous reset clears both to zero.
- R7: For every non-NaN input, narrowing the binary32 output back to binary16 gives the original 16-bit pattern (the conversion is exact).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pattern is valid this cycle |
| in_half | input | 16 | binary16 bit pattern |
| out_valid | output | 1 | Output result is valid |
| out_wide | output | OUT_W (32 or 64) | binary32 or binary64 bit pattern |

## Verification
A faulty leading-one position shows up directly at the ports. It shifts both the exponent and the mantissa of a subnormal conversion: the output exponent moves off the value 103+p, and the narrowed result no longer matches the input. Either symptom is visible on that same input, one clock after it is presented.

A wrong class decode surfaces the same way: it corrupts the exponent field of the very next result, for example a zero that gains an exponent or a NaN that loses its payload. A stuck valid stage shows as a missing or extra strobe one cycle after the input. Running the exhaustive sweep over all 65,536 patterns therefore exposes any single bad encoder or decode path within one cycle of the offending pattern.

// File: rtl/hw_pkg.sv
package hw_pkg;

    localparam int HEXP_W = 5;
    localparam int HMAN_W = 10;
    localparam int HBIAS  = 15;
    localparam int POS_W  = $clog2(HMAN_W);

    typedef struct packed {
        logic              sgn;
        logic [HEXP_W-1:0] exp;
        logic [HMAN_W-1:0] man;
    } half_t;

    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_SUB  = 2'd1,
        CL_NORM = 2'd2,
        CL_SPEC = 2'd3
    } hclass_e;

    function automatic hclass_e classify(input half_t h);
        if (h.exp == '1)       return CL_SPEC;
        else if (h.exp != '0)  return CL_NORM;
        else if (h.man != '0)  return CL_SUB;
        else                   return CL_ZERO;
    endfunction

    function automatic int wide_exp_w(input bit wide64);
        return wide64 ? 11 : 8;
    endfunction

    function automatic int wide_man_w(input bit wide64);
        return wide64 ? 52 : 23;
    endfunction

endpackage

// File: rtl/hw_lead_one.sv
module hw_lead_one #(
    parameter int W     = 10,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos
);
    // Priority encoder: the highest set bit wins; all-zero yields 0.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/hw_assemble.sv
module hw_assemble
    import hw_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  half_t             h,
    input  hclass_e           cls,
    input  logic [POS_W-1:0]  pos,
    output logic [EW+MW:0]    wide
);
    localparam int OBIAS = (1 << (EW - 1)) - 1;
    localparam int DELTA = OBIAS - HBIAS;
    localparam int PAD   = MW - HMAN_W;

    logic [EW-1:0]     e_out;
    logic [HMAN_W-1:0] m_out;
    logic [HMAN_W:0]   shifted;
    logic [POS_W-1:0]  shamt;

    always_comb begin
        shamt   = POS_W'(HMAN_W) - pos;
        shifted = {1'b0, h.man} << shamt;
        case (cls)
            CL_ZERO: begin
                e_out = '0;
                m_out = '0;
            end
            CL_SPEC: begin
                e_out = '1;
                m_out = h.man;
            end
            CL_NORM: begin
                e_out = EW'(h.exp) + EW'(DELTA);
                m_out = h.man;
            end
            default: begin
                e_out = EW'(DELTA - (HMAN_W - 1)) + EW'(pos);
                m_out = shifted[HMAN_W-1:0];
            end
        endcase
        wide = {h.sgn, e_out, m_out, {PAD{1'b0}}};
    end
endmodule

// File: rtl/hw_widen.sv
module hw_widen
    import hw_pkg::*;
#(
    parameter bit WIDE64  = 1'b0,
    parameter bit REG_OUT = 1'b1,
    parameter int OUT_W   = WIDE64 ? 64 : 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [15:0]      in_half,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_wide
);
    localparam int EW    = wide_exp_w(WIDE64);
    localparam int MW    = wide_man_w(WIDE64);
    localparam int DELTA = ((1 << (EW - 1)) - 1) - HBIAS;

    half_t            h;
    hclass_e          cls;
    logic [POS_W-1:0] pos;
    logic [OUT_W-1:0] wide_c;

    always_comb begin
        h   = half_t'(in_half);
        cls = classify(h);
    end

    hw_lead_one #(.W(HMAN_W), .POS_W(POS_W)) u_lead (
        .vec (h.man),
        .pos (pos)
    );

    hw_assemble #(.EW(EW), .MW(MW)) u_asm (
        .h    (h),
        .cls  (cls),
        .pos  (pos),
        .wide (wide_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    out_wide  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) out_wide <= wide_c;
                end
            end

            p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> out_valid == $past(in_valid));
            p_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(in_valid)) |-> $stable(out_wide));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_wide  = wide_c;
        end
    endgenerate

    // Combinational result vs. input pattern
    p_sign_r1: assert property (@(posedge clk) disable iff (rst)
        wide_c[OUT_W-1] == in_half[15]);
    p_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_half[14:0] == 15'd0) |-> (wide_c[OUT_W-2:0] == '0));
    p_lead_one_r3: assert property (@(posedge clk) disable iff (rst)
        (cls == CL_SUB) |-> ((h.man >> pos) == 10'd1));
    p_sub_exp_r3: assert property (@(posedge clk) disable iff (rst)
        (cls == CL_SUB) |-> (int'(wide_c[OUT_W-2 -: EW]) <= DELTA
                             && int'(wide_c[OUT_W-2 -: EW]) >= DELTA - 9));
    p_special_r4: assert property (@(posedge clk) disable iff (rst)
        (in_half[14:10] == 5'h1f) |-> (wide_c[OUT_W-2 -: EW] == '1
                                       && wide_c[MW-1 -: HMAN_W] == in_half[9:0]));
    p_normal_r5: assert property (@(posedge clk) disable iff (rst)
        (cls == CL_NORM) |-> (int'(wide_c[OUT_W-2 -: EW]) == int'(in_half[14:10]) + DELTA));
endmodule

// File: tb/hw_widen_bench.sv
module hw_widen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = 16'h0;
    logic        out_valid;
    logic [31:0] out_wide;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hw_widen u_hw_widen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
        .out_valid(out_valid), .out_wide(out_wide)
    );

    // {half, expected single}
    localparam logic [47:0] VEC [16] = '{
        {16'h0000, 32'h00000000},  // R2 +0
        {16'h8000, 32'h80000000},  // R1 R2 -0
        {16'h3C00, 32'h3F800000},  // R5 1.0
        {16'hC000, 32'hC0000000},  // R1 R5 -2.0
        {16'h7BFF, 32'h477FE000},  // R5 max normal
        {16'h0400, 32'h38800000},  // R5 min normal
        {16'h3555, 32'h3EAAA000},  // R5 mixed mantissa
        {16'h0001, 32'h33800000},  // R3 min subnormal
        {16'h8001, 32'hB3800000},  // R3 negative subnormal
        {16'h0003, 32'h34400000},  // R3 p=1
        {16'h0200, 32'h38000000},  // R3 p=9
        {16'h03FF, 32'h387FC000},  // R3 max subnormal
        {16'h7C00, 32'h7F800000},  // R4 +inf
        {16'hFC00, 32'hFF800000},  // R4 -inf
        {16'h7E00, 32'h7FC00000},  // R4 NaN
        {16'hFD55, 32'hFFAAA000}   // R4 NaN payload
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] narrow(input logic [31:0] f);
        logic [7:0]  e;
        logic [10:0] full;
        e    = f[30:23];
        full = {1'b1, f[22:13]};
        if (e == 8'd0)        return {f[31], 15'd0};
        else if (e == 8'hff)  return {f[31], 5'h1f, f[22:13]};
        else if (e >= 8'd113) return {f[31], 5'(e - 8'd112), f[22:13]};
        else                  return {f[31], 5'd0, 10'(full >> (8'd113 - e))};
    endfunction

    task automatic convert(input logic [15:0] h);
        @(negedge clk);
        in_half  = h;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R6 reset data", out_wide, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < 16; i++) begin
            convert(VEC[i][47:32]);
            chk("R1-R5 table", out_wide, VEC[i][31:0]);
            chk("R6 valid", {31'd0, out_valid}, 32'd1);
        end

        // R6: hold while in_valid is low
        convert(16'h3C00);
        @(negedge clk);
        in_half = 16'h4000;
        @(posedge clk);
        @(negedge clk);
        chk("R6 hold data", out_wide, 32'h3F800000);
        chk("R6 valid low", {31'd0, out_valid}, 32'd0);

        // Exhaustive sweep: R4 on NaN, R7 on the rest, R1 on all
        for (int v = 0; v < 65536; v++) begin
            logic [15:0] h;
            h = 16'(v);
            convert(h);
            if (out_wide[31] !== h[15]) chk("R1 sign", {31'd0, out_wide[31]}, {31'd0, h[15]});
            if (h[14:10] == 5'h1f && h[9:0] != 10'd0)
                chk("R4 NaN payload", out_wide, {h[15], 8'hff, h[9:0], 13'd0});
            else
                chk("R7 round trip", {16'd0, narrow(out_wide)}, {16'd0, h});
        end

        // R6 synchronous reset clears
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 reset clears data", out_wide, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule